// File: doc/BRIEF.md
# Secure-aware interrupt register filter

This block is a slice of an interrupt controller for a parameterised number of sources (32 by default). For each source it keeps a class bit (secure or non-secure), an enable bit and a pending bit. Software reaches these bits through a simple register port. Every access on that port carries a non-secure flag. The block filters each access bit by bit against the class of the interrupt that the bit belongs to.

A secure access sees and changes everything. A non-secure access reads zero in every bit that belongs to a secure interrupt, and its writes to those bits are dropped. Bits of non-secure interrupts in the same word are still read and written normally. Only a secure access can change the class bits or the routing control.

A rising edge on a source latches its pending bit. Pending, enabled interrupts drive two registered request lines toward one processor. Non-secure interrupts always use the normal request line. Secure interrupts use either the normal line or the fast line, as chosen by a control bit.

Top module: `sec_irq_filter`

## Requirements
- R1: After reset every class bit is 0 (secure), every enable and pending bit is 0, the fast-routing control bit is 0, and both request outputs are low.
- R2: A secure access (acc_ns=0) reads and writes the bits of all interrupts, both secure and non-secure.
- R3: In a non-secure read (acc_ns=1), every bit position whose class bit is 0 returns 0, at every offset.
- R4: A non-secure write to enable-set, enable-clear, pending-set or pending-clear changes only the bits whose class bit is 1. The other bits of the same word keep their state.
- R5: The class register (offset 0x00, bit i = 1 means interrupt i is non-secure) is changed only by a secure write. A non-secure write to it has no effect.
- R6: A 0-to-1 transition on src_i[i] sets pending bit i on the next clock edge. A source held high does not set the bit again once it is cleared. If an edge and a pending-clear of the same bit fall in the same cycle, the bit ends up set.
- R7: A pending bit falls only when 1 is written to its position at pending-clear (offset 0x10). Zeros written there have no effect. Pending-set (0x0C) and pending-clear both read back the pending bits.
- R8: irq_o is registered. It goes high one clock after some interrupt is pending and enabled and is either non-secure, or secure while the control bit is 0. A pending interrupt that is not enabled drives nothing.
- R9: When control bit 0 (offset 0x14) is 1, pending and enabled secure interrupts raise fiq_o one clock later and do not raise irq_o. Non-secure interrupts still reach only irq_o.
- R10: The control register at offset 0x14 is secure-only. A non-secure read of it returns 0 and a non-secure write to it is ignored. A secure read returns the routing bit in bit 0.
- R11: A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 returns 0, and a write to such an offset changes nothing, whatever the value of acc_ns.
- R12: Enable-set (0x04) sets each enable bit written as 1, and enable-clear (0x08) clears each enable bit written as 1. Both offsets read back the enable bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source lines, edge sensitive |
| acc_en | input | 1 | Register access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ns | input | 1 | 1 = non-secure access, 0 = secure access |
| acc_addr | input | ADDR_W | Byte offset of the register |
| acc_wdata | input | NUM_SRC | Write data, one bit per interrupt |
| acc_rdata | output | NUM_SRC | Read data, valid in the cycle of a read, zero otherwise |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
The bench writes mixed words in which secure and non-secure bits sit side by side. A design that gates a whole word by its security flag, rather than each bit, would drop or leak the neighbouring bits. It also tries non-secure writes to the class and control registers; a filter that forgets these two would let non-secure software reclaim secure interrupts or reroute them. It drives a source edge in the same cycle as a pending-clear, holds a source high across a clear, and writes zeros to the clear register. Each of these catches a pending latch that uses the wrong precedence or is level sensitive. Finally it times each request line to the exact cycle and flips the routing bit while interrupts are pending, which exposes an output that is not registered or that leaks secure interrupts onto the wrong line.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;

  // Register byte offsets
  localparam int unsigned OFF_CLASS = 'h00;
  localparam int unsigned OFF_ENSET = 'h04;
  localparam int unsigned OFF_ENCLR = 'h08;
  localparam int unsigned OFF_PSET  = 'h0C;
  localparam int unsigned OFF_PCLR  = 'h10;
  localparam int unsigned OFF_CTRL  = 'h14;

  typedef enum logic [2:0] {
    SEL_CLASS,
    SEL_ENSET,
    SEL_ENCLR,
    SEL_PSET,
    SEL_PCLR,
    SEL_CTRL,
    SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/sec_irq_edge.sv
module sec_irq_edge #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic last_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= src_i[i];
    end
    assign rise_o[i] = src_i[i] & ~last_q;
  end

endmodule

// File: rtl/sec_irq_regs.sv
module sec_irq_regs
  import sec_irq_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic              acc_ns,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [N-1:0]      acc_wdata,
  input  logic [N-1:0]      rise_i,
  output logic [N-1:0]      acc_rdata,
  output logic [N-1:0]      class_o,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      pend_o,
  output logic              fiq_sel_o
);

  // Map a byte offset to a register; anything else is unmapped
  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    if      (a == ADDR_W'(OFF_CLASS)) s = SEL_CLASS;
    else if (a == ADDR_W'(OFF_ENSET)) s = SEL_ENSET;
    else if (a == ADDR_W'(OFF_ENCLR)) s = SEL_ENCLR;
    else if (a == ADDR_W'(OFF_PSET))  s = SEL_PSET;
    else if (a == ADDR_W'(OFF_PCLR))  s = SEL_PCLR;
    else if (a == ADDR_W'(OFF_CTRL))  s = SEL_CTRL;
    else                              s = SEL_NONE;
    return s;
  endfunction

  // Bits an access may touch: everything when secure, non-secure class bits otherwise
  function automatic logic [N-1:0] reach(input logic [N-1:0] cls, input logic ns);
    return ns ? cls : {N{1'b1}};
  endfunction

  logic [N-1:0] class_q, en_q, pend_q;
  logic         fiq_q;

  reg_sel_e     sel;
  logic         wr_fire, rd_fire;
  logic [N-1:0] vis;
  logic [N-1:0] wbits;
  logic [N-1:0] en_set, en_clr, pd_set, pd_clr;
  logic         class_wr, ctrl_wr;

  assign sel      = decode(acc_addr);
  assign wr_fire  = acc_en & acc_wr;
  assign rd_fire  = acc_en & ~acc_wr;
  assign vis      = reach(class_q, acc_ns);
  assign wbits    = acc_wdata & vis;

  assign class_wr = wr_fire & ~acc_ns & (sel == SEL_CLASS);
  assign ctrl_wr  = wr_fire & ~acc_ns & (sel == SEL_CTRL);
  assign en_set   = (wr_fire && sel == SEL_ENSET) ? wbits : '0;
  assign en_clr   = (wr_fire && sel == SEL_ENCLR) ? wbits : '0;
  assign pd_set   = (wr_fire && sel == SEL_PSET)  ? wbits : '0;
  assign pd_clr   = (wr_fire && sel == SEL_PCLR)  ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      class_q <= '0;
      en_q    <= '0;
      pend_q  <= '0;
      fiq_q   <= 1'b0;
    end else begin
      if (class_wr) class_q <= acc_wdata;
      if (ctrl_wr)  fiq_q   <= acc_wdata[0];
      en_q   <= (en_q & ~en_clr) | en_set;
      // a fresh edge wins over a clear of the same bit
      pend_q <= (pend_q & ~pd_clr) | pd_set | rise_i;
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (rd_fire) begin
      unique case (sel)
        SEL_CLASS:          acc_rdata = class_q & vis;
        SEL_ENSET,
        SEL_ENCLR:          acc_rdata = en_q & vis;
        SEL_PSET,
        SEL_PCLR:           acc_rdata = pend_q & vis;
        SEL_CTRL:           acc_rdata[0] = fiq_q & ~acc_ns;
        default:            acc_rdata = '0;
      endcase
    end
  end

  assign class_o   = class_q;
  assign en_o      = en_q;
  assign pend_o    = pend_q;
  assign fiq_sel_o = fiq_q;

  // R3
  ns_read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && acc_ns) |-> ((acc_rdata & ~class_q) == '0));

  // R4
  ns_enable_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && acc_ns) |=> (((en_q ^ $past(en_q)) & ~$past(class_q)) == '0));

  // R5
  ns_class_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && acc_ns) |=> $stable(class_q));

  // R7
  pend_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && sel == SEL_PCLR) |=> (($past(pend_q) & ~pend_q) == '0));

  // R10
  ns_ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && acc_ns) |=> $stable(fiq_q));

endmodule

// File: rtl/sec_irq_route.sv
module sec_irq_route #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] class_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] pend_i,
  input  logic         fiq_sel_i,
  output logic         irq_o,
  output logic         fiq_o
);

  logic [N-1:0] live;
  logic         ns_hit, s_hit;

  assign live   = pend_i & en_i;
  assign ns_hit = |(live & class_i);
  assign s_hit  = |(live & ~class_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= ns_hit | (s_hit & ~fiq_sel_i);
      fiq_o <= s_hit & fiq_sel_i;
    end
  end

  // R8
  ns_reaches_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ns_hit |=> irq_o);

  // R9
  fiq_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> $past(fiq_sel_i));

  // R9
  fiq_follows_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit && fiq_sel_i) |=> fiq_o);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ns_hit && !(s_hit && !fiq_sel_i)) |=> !irq_o);

endmodule

// File: rtl/sec_irq_filter.sv
module sec_irq_filter #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               acc_en,
  input  logic               acc_wr,
  input  logic               acc_ns,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [NUM_SRC-1:0] acc_wdata,
  output logic [NUM_SRC-1:0] acc_rdata,
  output logic               irq_o,
  output logic               fiq_o
);

  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] cls, en, pend;
  logic               fiq_sel;

  sec_irq_edge #(.N(NUM_SRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_i),
    .rise_o (rise)
  );

  sec_irq_regs #(.N(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_ns    (acc_ns),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .rise_i    (rise),
    .acc_rdata (acc_rdata),
    .class_o   (cls),
    .en_o      (en),
    .pend_o    (pend),
    .fiq_sel_o (fiq_sel)
  );

  sec_irq_route #(.N(NUM_SRC)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .class_i   (cls),
    .en_i      (en),
    .pend_i    (pend),
    .fiq_sel_i (fiq_sel),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
  );

  // R6
  edge_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend & $past(rise)) == $past(rise)));

endmodule

// File: tb/test_sec_irq_filter.sv
module test_sec_irq_filter;

  localparam int NV = 38;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        acc_en = 1'b0, acc_wr = 1'b0, acc_ns = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sec_irq_filter i_sec_irq_filter (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_ns(acc_ns),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // {is_read, ns, offset, data (write value or expected read), requirement}
  localparam logic [49:0] VECS [0:NV-1] = '{
    {1'b1, 1'b0, 8'h00, 32'h00000000, 8'd1},   // R1
    {1'b1, 1'b0, 8'h04, 32'h00000000, 8'd1},   // R1
    {1'b1, 1'b0, 8'h0C, 32'h00000000, 8'd1},   // R1
    {1'b1, 1'b0, 8'h14, 32'h00000000, 8'd1},   // R1
    {1'b0, 1'b0, 8'h00, 32'h0000FFFF, 8'd2},   // R2
    {1'b1, 1'b0, 8'h00, 32'h0000FFFF, 8'd2},   // R2
    {1'b0, 1'b1, 8'h00, 32'hFFFFFFFF, 8'd5},   // R5
    {1'b1, 1'b0, 8'h00, 32'h0000FFFF, 8'd5},   // R5
    {1'b1, 1'b1, 8'h00, 32'h0000FFFF, 8'd3},   // R3
    {1'b0, 1'b1, 8'h04, 32'hFFFFFFFF, 8'd4},   // R4
    {1'b1, 1'b0, 8'h04, 32'h0000FFFF, 8'd4},   // R4
    {1'b0, 1'b0, 8'h04, 32'h00FF0000, 8'd2},   // R2
    {1'b1, 1'b1, 8'h04, 32'h0000FFFF, 8'd3},   // R3
    {1'b0, 1'b1, 8'h08, 32'h00F000F0, 8'd4},   // R4
    {1'b1, 1'b0, 8'h08, 32'h00FFFF0F, 8'd12},  // R12
    {1'b0, 1'b1, 8'h0C, 32'h80000001, 8'd4},   // R4
    {1'b1, 1'b0, 8'h0C, 32'h00000001, 8'd4},   // R4
    {1'b0, 1'b0, 8'h0C, 32'h80000000, 8'd2},   // R2
    {1'b1, 1'b1, 8'h10, 32'h00000001, 8'd3},   // R3
    {1'b0, 1'b1, 8'h10, 32'h80000001, 8'd4},   // R4
    {1'b1, 1'b0, 8'h0C, 32'h80000000, 8'd4},   // R4
    {1'b0, 1'b0, 8'h10, 32'h00000000, 8'd7},   // R7
    {1'b1, 1'b0, 8'h0C, 32'h80000000, 8'd7},   // R7
    {1'b0, 1'b1, 8'h14, 32'h00000001, 8'd10},  // R10
    {1'b1, 1'b0, 8'h14, 32'h00000000, 8'd10},  // R10
    {1'b0, 1'b0, 8'h14, 32'h00000001, 8'd10},  // R10
    {1'b1, 1'b0, 8'h14, 32'h00000001, 8'd10},  // R10
    {1'b1, 1'b1, 8'h14, 32'h00000000, 8'd10},  // R10
    {1'b0, 1'b0, 8'h18, 32'hFFFFFFFF, 8'd11},  // R11
    {1'b1, 1'b0, 8'h18, 32'h00000000, 8'd11},  // R11
    {1'b0, 1'b1, 8'h03, 32'hFFFFFFFF, 8'd11},  // R11
    {1'b1, 1'b0, 8'h00, 32'h0000FFFF, 8'd11},  // R11
    {1'b1, 1'b0, 8'h04, 32'h00FFFF0F, 8'd11},  // R11
    {1'b0, 1'b0, 8'h14, 32'h00000000, 8'd10},  // R10
    {1'b0, 1'b0, 8'h10, 32'hFFFFFFFF, 8'd7},   // R7
    {1'b0, 1'b0, 8'h08, 32'hFFFFFFFF, 8'd12},  // R12
    {1'b1, 1'b0, 8'h0C, 32'h00000000, 8'd7},   // R7
    {1'b1, 1'b0, 8'h04, 32'h00000000, 8'd12}   // R12
  };

  task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; commits at the next rising edge; returns at the falling edge after
  task automatic wr(input logic ns, input logic [7:0] a, input logic [31:0] d);
    acc_en = 1'b1; acc_wr = 1'b1; acc_ns = ns; acc_addr = a; acc_wdata = d;
    @(posedge clk);
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; acc_ns = 1'b0; acc_wdata = '0;
  endtask

  task automatic rd(input logic ns, input logic [7:0] a, output logic [31:0] d);
    acc_en = 1'b1; acc_wr = 1'b0; acc_ns = ns; acc_addr = a;
    #1;
    d = acc_rdata;
    acc_en = 1'b0; acc_ns = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: request lines idle after reset
    chk("irq after reset", 1, {31'b0, irq_o}, 32'h0);
    chk("fiq after reset", 1, {31'b0, fiq_o}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VECS[k][49]) begin
        rd(VECS[k][48], VECS[k][47:40], r);
        chk($sformatf("vector %0d read", k), int'(VECS[k][7:0]), r, VECS[k][39:8]);
      end else begin
        wr(VECS[k][48], VECS[k][47:40], VECS[k][39:8]);
      end
    end

    // Class = 0x0000FFFF, all disabled, nothing pending, routing bit 0
    wr(1'b0, 8'h04, 32'h00010001);

    // R6 / R8: edge on non-secure source 0
    src_i[0] = 1'b1;
    @(negedge clk);
    rd(1'b0, 8'h0C, r);
    chk("pending after edge", 6, r, 32'h00000001);
    chk("irq one cycle later not yet", 8, {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("irq after latency", 8, {31'b0, irq_o}, 32'h1);
    chk("fiq stays low for non-secure", 9, {31'b0, fiq_o}, 32'h0);

    // R6: clear while source stays high does not relatch
    wr(1'b1, 8'h10, 32'h00000001);
    rd(1'b0, 8'h0C, r);
    chk("held level does not relatch", 6, r, 32'h0);
    @(negedge clk);
    chk("irq drops after clear", 8, {31'b0, irq_o}, 32'h0);

    // R8: secure source 16 reaches irq while routing bit is 0
    src_i[16] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("secure on irq", 8, {irq_o, fiq_o}, 32'h2);

    // R9: routing bit moves secure interrupts to fiq
    wr(1'b0, 8'h14, 32'h00000001);
    @(negedge clk);
    chk("secure moved to fiq", 9, {irq_o, fiq_o}, 32'h1);

    // R9: non-secure still on irq alongside fiq
    src_i[0] = 1'b0;
    @(negedge clk);
    src_i[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("both lines", 9, {irq_o, fiq_o}, 32'h3);

    // R6: edge and clear of the same bit in one cycle, edge wins
    src_i[1] = 1'b1;
    wr(1'b0, 8'h10, 32'h00000002);
    rd(1'b0, 8'h0C, r);
    chk("edge beats clear", 6, r, 32'h00010003);

    // R8: disabled pending bit 1 does not drive irq
    wr(1'b0, 8'h10, 32'h00000001);
    @(negedge clk);
    chk("disabled pending silent", 8, {irq_o, fiq_o}, 32'h1);

    // R4: non-secure clear of a secure pending bit is dropped
    wr(1'b1, 8'h10, 32'h00010000);
    @(negedge clk);
    chk("fiq kept after ns clear", 4, {31'b0, fiq_o}, 32'h1);
    rd(1'b0, 8'h0C, r);
    chk("secure pending kept", 4, r, 32'h00010002);

    finish_run();
  end

endmodule